// File: doc/BRIEF.md
# Seven-Pin Bidirectional Port with Input Pullups

This block is a small register-mapped general-purpose I/O port with seven pins on a simple synchronous register bus. Software uses three 8-bit registers to control it. The output latch holds the level each pin drives. The direction register picks, bit by bit, whether a pin drives or listens. The pullup-enable register asks for a weak pull to the supply on pins that listen. For every pin the block gives the pad an output value, an output enable and a pullup enable, and it samples the pad's input level.

Reading the data address returns a mix, bit by bit. A pin set as an output shows its latch bit. A pin set as an input shows its synchronized pad level. The latch accepts writes whatever the direction, so a value can be loaded before the pin is switched to an output. The pullup of a pin is forced off while that pin is an output.

Top module: `seven_pin_port`

## Requirements
- R1: After reset the latch, direction and pullup-enable registers are all zero. Every pin is an input with no pullup, and pinOut, pinOe and pinPullEn are all 0.
- R2: A read of address 0x02 returns, for each bit 6..0, the latch bit when the direction bit is 1 and the synchronized pad level when the direction bit is 0.
- R3: A write to 0x02 loads busWrData[6:0] into the latch in every direction state, and pinOut shows it on the next cycle. A write made while a pin is an input leaves that pin's read-back level unchanged.
- R4: A write to 0x06 loads busWrData[6:0] into the direction register. pinOe equals the direction register, so a 1 marks an output that drives its latch bit.
- R5: pinPullEn for each bit is 1 only when its pullup-enable bit is 1 and its direction bit is 0. It drops in the same cycle the direction bit becomes 1.
- R6: A write to 0x0E loads busWrData[6:0] into the pullup-enable register. Reads of 0x06 and 0x0E return the stored register, and bit 7 of every read is 0.
- R7: A pad input passes through two flops before it reaches read-back. A pad change made between clock edges appears in a read of 0x02 that comes after the second rising edge, and not before it.
- R8: Reads of any address other than 0x02, 0x06 and 0x0E return 0x00, and writes to such addresses change no register.
- R9: busRdData is 0x00 in every cycle in which busRdEn is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | 8 | Register address |
| busWrEn | input | 1 | Write strobe, acts on the rising edge |
| busRdEn | input | 1 | Read strobe, data valid in the same cycle |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data (combinational) |
| pinIn | input | 7 | Pad input levels, asynchronous |
| pinOut | output | 7 | Level each pin drives when it is an output |
| pinOe | output | 7 | Output enable for each pin |
| pinPullEn | output | 7 | Pullup request for each pin |

## Verification
Pad outputs come straight from the registers, so a corrupted latch, direction or pullup bit shows up on pinOut, pinOe or pinPullEn in the cycle after the faulty write. A pullup left on for an output is visible in that same cycle. A wrong read-back choice for a bit, or a synchronizer with the wrong depth, shows only when the data address is read. The bench therefore reads it often while changing pad levels, so that a latency off by one cycle fails within two cycles of a pad change.

// File: rtl/seven_pin_port_pkg.sv
package seven_pin_port_pkg;

  // Strobes passed from the address decoder to the register datapath.
  typedef struct packed {
    logic wrLatch;
    logic wrDir;
    logic wrPull;
    logic rdLatch;
    logic rdDir;
    logic rdPull;
  } portStrobe_t;

  localparam portStrobe_t STROBE_IDLE = '0;

endpackage

// File: rtl/seven_pin_port_ctrl.sv
module seven_pin_port_ctrl
  import seven_pin_port_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] ADDR_LATCH = 8'h02,
  parameter logic [ADDR_W-1:0] ADDR_DIR   = 8'h06,
  parameter logic [ADDR_W-1:0] ADDR_PULL  = 8'h0E
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  output portStrobe_t       strobe,
  output logic              addrHit
);

  logic hitLatch, hitDir, hitPull;

  always_comb begin
    hitLatch = (busAddr == ADDR_LATCH);
    hitDir   = (busAddr == ADDR_DIR);
    hitPull  = (busAddr == ADDR_PULL);
    addrHit  = hitLatch | hitDir | hitPull;
  end

  always_comb begin
    strobe         = STROBE_IDLE;
    strobe.wrLatch = busWrEn & hitLatch;
    strobe.wrDir   = busWrEn & hitDir;
    strobe.wrPull  = busWrEn & hitPull;
    strobe.rdLatch = busRdEn & hitLatch;
    strobe.rdDir   = busRdEn & hitDir;
    strobe.rdPull  = busRdEn & hitPull;
  end

endmodule

// File: rtl/seven_pin_port_dp.sv
module seven_pin_port_dp
  import seven_pin_port_pkg::*;
#(
  parameter int PIN_COUNT   = 7,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  portStrobe_t          strobe,
  input  logic [DATA_W-1:0]    busWrData,
  output logic [DATA_W-1:0]    busRdData,
  input  logic [PIN_COUNT-1:0] pinIn,
  output logic [PIN_COUNT-1:0] pinOut,
  output logic [PIN_COUNT-1:0] pinOe,
  output logic [PIN_COUNT-1:0] pinPullEn
);

  localparam int PAD_W = DATA_W - PIN_COUNT;

  logic [PIN_COUNT-1:0] latchReg, dirReg, pullReg;
  logic [PIN_COUNT-1:0] wrBits;
  logic [PIN_COUNT-1:0] syncStage [SYNC_STAGES];
  logic [PIN_COUNT-1:0] pinLevel;
  logic [PIN_COUNT-1:0] rdVec;
  logic [PAD_W-1:0]     unusedWrBits;

  assign wrBits       = busWrData[PIN_COUNT-1:0];
  assign unusedWrBits = busWrData[DATA_W-1:PIN_COUNT];

  // Register file: the latch takes writes whatever the direction.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchReg <= '0;
      dirReg   <= '0;
      pullReg  <= '0;
    end else begin
      if (strobe.wrLatch) latchReg <= wrBits;
      if (strobe.wrDir)   dirReg   <= wrBits;
      if (strobe.wrPull)  pullReg  <= wrBits;
    end
  end

  // Input synchronizer chain.
  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncStage[s] <= '0;
      end else if (s == 0) begin
        syncStage[s] <= pinIn;
      end else begin
        syncStage[s] <= syncStage[(s == 0) ? 0 : s-1];
      end
    end
  end
  assign pinLevel = syncStage[SYNC_STAGES-1];

  // Per-pin pad control.
  for (genvar p = 0; p < PIN_COUNT; p++) begin : g_pin
    assign pinOut[p]    = latchReg[p];
    assign pinOe[p]     = dirReg[p];
    assign pinPullEn[p] = pullReg[p] & ~dirReg[p];
  end

  // Read-back mux.
  always_comb begin
    rdVec = '0;
    if (strobe.rdLatch)     rdVec = (latchReg & dirReg) | (pinLevel & ~dirReg);
    else if (strobe.rdDir)  rdVec = dirReg;
    else if (strobe.rdPull) rdVec = pullReg;
  end
  assign busRdData = {{PAD_W{1'b0}}, rdVec};

  // Cycles since reset, saturating; used only to qualify the latency check.
  logic [1:0] warmCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                warmCnt <= '0;
    else if (warmCnt != 2'd3) warmCnt <= warmCnt + 2'd1;
  end

  a_r3_latch_takes_write: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrLatch |=> pinOut == $past(wrBits));

  a_r4_dir_drives_oe: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrDir |=> pinOe == $past(wrBits));

  a_r5_no_pull_on_output: assert property (@(posedge clk) disable iff (!rstN)
    (pinPullEn & pinOe) == '0);

  a_r6_top_bit_low: assert property (@(posedge clk) disable iff (!rstN)
    busRdData[DATA_W-1] == 1'b0);

  a_r7_two_flop_latency: assert property (@(posedge clk) disable iff (!rstN)
    (warmCnt >= 2'd2 && strobe.rdLatch && SYNC_STAGES == 2)
      |-> ((busRdData[PIN_COUNT-1:0] & ~pinOe) == ($past(pinIn, 2) & ~pinOe)));

endmodule

// File: rtl/seven_pin_port.sv
module seven_pin_port
  import seven_pin_port_pkg::*;
#(
  parameter int PIN_COUNT   = 7,
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busWrEn,
  input  logic                 busRdEn,
  input  logic [DATA_W-1:0]    busWrData,
  output logic [DATA_W-1:0]    busRdData,
  input  logic [PIN_COUNT-1:0] pinIn,
  output logic [PIN_COUNT-1:0] pinOut,
  output logic [PIN_COUNT-1:0] pinOe,
  output logic [PIN_COUNT-1:0] pinPullEn
);

  portStrobe_t strobe;
  logic        addrHit;

  seven_pin_port_ctrl #(
    .ADDR_W (ADDR_W)
  ) u_ctrl (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .busRdEn (busRdEn),
    .strobe  (strobe),
    .addrHit (addrHit)
  );

  seven_pin_port_dp #(
    .PIN_COUNT   (PIN_COUNT),
    .DATA_W      (DATA_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .busWrData (busWrData),
    .busRdData (busRdData),
    .pinIn     (pinIn),
    .pinOut    (pinOut),
    .pinOe     (pinOe),
    .pinPullEn (pinPullEn)
  );

  a_r8_unmapped_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && !addrHit) |-> busRdData == '0);

  a_r8_unmapped_write_no_change: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && !addrHit) |=> ($stable(pinOut) && $stable(pinOe) && $stable(pinPullEn)));

  a_r9_idle_read_zero: assert property (@(posedge clk) disable iff (!rstN)
    !busRdEn |-> busRdData == '0);

endmodule

// File: tb/seven_pin_port_bench.sv
module seven_pin_port_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] busAddr = '0;
  logic       busWrEn = 1'b0;
  logic       busRdEn = 1'b0;
  logic [7:0] busWrData = '0;
  logic [7:0] busRdData;
  logic [6:0] pinIn;
  logic [6:0] pinOut, pinOe, pinPullEn;

  // Pad environment: extDrv=1 means an outside driver forces extVal.
  logic [6:0] extDrv = '0;
  logic [6:0] extVal = '0;

  int checks = 0;
  int fails  = 0;

  // Reference state.
  int mLatch, mDir, mPull;
  int mHist[$];
  int lastDut;

  always #4 clk = ~clk;

  seven_pin_port u_seven_pin_port (
    .clk (clk), .rstN (rstN), .busAddr (busAddr), .busWrEn (busWrEn),
    .busRdEn (busRdEn), .busWrData (busWrData), .busRdData (busRdData),
    .pinIn (pinIn), .pinOut (pinOut), .pinOe (pinOe), .pinPullEn (pinPullEn)
  );

  // Pad resolution: own driver, outside driver, pullup, else floats low.
  always_comb begin
    for (int i = 0; i < 7; i++) begin
      if (pinOe[i])          pinIn[i] = pinOut[i];
      else if (extDrv[i])    pinIn[i] = extVal[i];
      else if (pinPullEn[i]) pinIn[i] = 1'b1;
      else                   pinIn[i] = 1'b0;
    end
  end

  function automatic int modelLevel();
    int lv = 0;
    for (int i = 0; i < 7; i++) begin
      int b;
      if ((mDir >> i) & 1)       b = (mLatch >> i) & 1;
      else if (extDrv[i])        b = extVal[i];
      else if ((mPull >> i) & 1) b = 1;
      else                       b = 0;
      lv |= b << i;
    end
    return lv;
  endfunction

  function automatic int modelRead(int addr, bit re);
    if (!re) return 0;
    case (addr)
      2:  return ((mLatch & mDir) | (mHist[0] & ~mDir)) & 8'h7F;
      6:  return mDir;
      14: return mPull;
      default: return 0;
    endcase
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  // One bus cycle; compare everything against the model before the edge.
  task automatic cyc(int addr, bit we, bit re, int wd);
    int lv;
    busAddr = addr[7:0]; busWrEn = we; busRdEn = re; busWrData = wd[7:0];
    #2;
    chk("R2/R6/R8/R9 readback", busRdData, modelRead(addr, re));
    chk("R3 pinOut", pinOut, mLatch);
    chk("R4 pinOe", pinOe, mDir);
    chk("R5 pinPullEn", pinPullEn, mPull & ~mDir & 8'h7F);
    lastDut = busRdData;
    @(posedge clk);
    lv = modelLevel();
    mHist.push_back(lv);
    void'(mHist.pop_front());
    if (we) begin
      case (addr)
        2:  mLatch = wd & 8'h7F;
        6:  mDir   = wd & 8'h7F;
        14: mPull  = wd & 8'h7F;
        default: ;
      endcase
    end
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    mLatch = 0; mDir = 0; mPull = 0;
    mHist = '{0, 0};
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state.
    chk("R1 pinOe reset", pinOe, 0);
    chk("R1 pinPullEn reset", pinPullEn, 0);
    chk("R1 pinOut reset", pinOut, 0);
    cyc(6, 0, 1, 0);  chk("R1 dir reset", lastDut, 8'h00);
    cyc(14, 0, 1, 0); chk("R1 pull reset", lastDut, 8'h00);
    cyc(2, 0, 1, 0);  chk("R1 data reset", lastDut, 8'h00);

    // R6, R5: pullups on all pins, bit 7 dropped.
    cyc(14, 1, 0, 8'hFF);
    cyc(14, 0, 1, 0);  chk("R6 pull readback bit7", lastDut, 8'h7F);
    chk("R5 pulls active on inputs", pinPullEn, 7'h7F);
    cyc(0, 0, 0, 0);
    cyc(2, 0, 1, 0);   chk("R2 pulled inputs read high", lastDut, 8'h7F);

    // R3: latch write while all pins are inputs.
    cyc(2, 1, 0, 8'h55);
    cyc(2, 0, 1, 0);   chk("R3 input readback unchanged", lastDut, 8'h7F);
    chk("R3 latch on pinOut", pinOut, 7'h55);

    // R4, R5, R6, R2: low nibble to outputs.
    cyc(6, 1, 0, 8'h8F);
    cyc(6, 0, 1, 0);   chk("R6 dir readback bit7", lastDut, 8'h0F);
    chk("R4 pinOe", pinOe, 7'h0F);
    chk("R5 pull dropped on outputs", pinPullEn, 7'h70);
    cyc(2, 0, 1, 0);   chk("R2 mixed readback", lastDut, 8'h75);

    // R7: outside driver pulls pins 6..4 low; visible after two edges.
    extDrv = 7'h70; extVal = 7'h00;
    cyc(2, 0, 1, 0);   chk("R7 before first edge", lastDut, 8'h75);
    cyc(2, 0, 1, 0);   chk("R7 after one edge", lastDut, 8'h75);
    cyc(2, 0, 1, 0);   chk("R7 after two edges", lastDut, 8'h05);

    // R8: unmapped write and read.
    cyc(3, 1, 0, 8'hFF);
    cyc(8'hE2, 1, 0, 8'h00);
    cyc(3, 0, 1, 0);   chk("R8 unmapped read", lastDut, 8'h00);
    cyc(2, 0, 1, 0);   chk("R8 data unchanged", lastDut, 8'h05);
    cyc(6, 0, 1, 0);   chk("R8 dir unchanged", lastDut, 8'h0F);
    cyc(14, 0, 1, 0);  chk("R8 pull unchanged", lastDut, 8'h7F);

    // R9: no read strobe.
    cyc(6, 0, 0, 0);   chk("R9 idle read zero", lastDut, 8'h00);

    // Mixed traffic against the model on every cycle.
    for (int n = 0; n < 600; n++) begin
      int a;
      case ($urandom % 5)
        0: a = 2;
        1: a = 6;
        2: a = 14;
        default: a = $urandom % 256;
      endcase
      if ($urandom % 4 == 0) begin
        extDrv = 7'($urandom);
        extVal = 7'($urandom);
      end
      cyc(a, ($urandom % 3) == 0, ($urandom % 4) != 0, $urandom % 256);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule